// File: doc/BRIEF.md
# Broadcast-or-Serial Internal Scan Wrapper

This block holds a set of internal scan chains, all of the same length, around a piece of logic under test. Two ways of loading share the same flops. In broadcast mode one scan input bit goes to the head of every chain on the same edge, so a pattern as long as one chain fills all of them at once. In serial mode the chains are joined end to end into one long chain. Any pattern can then be loaded, which recovers the faults that identical chain contents cannot reach.

When scan-enable is low, every chain flop loads its bit of a parallel capture bus coming from the logic under test. In broadcast mode the chain tails feed a multiple-input signature register. That register compacts the unloaded responses and shows its contents on a parallel output. The last chain's tail is also the scan output in both modes. Everything runs on one clock. An asynchronous active-low reset goes through a two-stage synchronizer, so its release is synchronous.

Top module: `scan_bcast_wrap`

## Requirements
- R1: While the reset input is low, every chain flop and every signature bit is zero, so scan_out and signature read zero.
- R2: With scan_en=1 and bcast_mode=1, the head flop of every chain takes scan_in on the same clock edge.
- R3: With scan_en=1 and bcast_mode=0, the head of chain 0 takes scan_in and the head of chain k (k>0) takes the tail of chain k-1. scan_out is the tail of the last chain in both modes.
- R4: With scan_en=1, flop j>0 of each chain takes flop j-1 of the same chain. The head is j=0 and the tail is j=L-1.
- R5: With scan_en=0, flop j of chain k loads capture_bus bit k*L+j on the clock edge.
- R6: With scan_en=1, bcast_mode=1 and sig_clr=0, the signature becomes {sig[W-2:0],0}, XORed with TAPS if sig[W-1] was 1, XORed with the chain tails as they were before the edge (tail of chain k into bit k). TAPS is 0x05 for W=5 (x^5+x^2+1) and 0x1D for W=8 (x^8+x^4+x^3+x^2+1).
- R7: With sig_clr=0 and either scan_en=0 or bcast_mode=0, the signature keeps its value.
- R8: sig_clr=1 zeroes the signature on the next edge and takes priority over the R6 update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single scan and capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial scan input bit |
| scan_en | input | 1 | 1 shifts the chains, 0 captures |
| bcast_mode | input | 1 | 1 broadcast to all chains, 0 one serial chain |
| sig_clr | input | 1 | Synchronous clear of the signature register |
| capture_bus | input | NUM_CHAINS*CHAIN_LEN | Parallel responses from the logic under test |
| scan_out | output | 1 | Tail of the last chain |
| signature | output | SIG_W | Signature register contents |

## Verification
The assertions assume that SIG_W is at least NUM_CHAINS and that CHAIN_LEN is at least 2. They also assume that scan_in, scan_en, bcast_mode, sig_clr and capture_bus are stable around the rising edge. The bench changes every input only on the falling edge and uses a 3x3 chain configuration with a 5-bit signature that meets these limits. It sweeps every capture pattern through serial unload and through broadcast load followed by compaction. A long pseudo-random mix of modes, clears and captures follows, with a bench-side model built from the requirements checked every cycle.

// File: rtl/scan_wrap_pkg.sv
package scan_wrap_pkg;

  // Feedback mask (lower terms) of a primitive polynomial for the signature width.
  function automatic logic [31:0] sig_taps(input int unsigned width);
    case (width)
      3:       sig_taps = 32'h0000_0003;
      4:       sig_taps = 32'h0000_0003;
      5:       sig_taps = 32'h0000_0005;
      6:       sig_taps = 32'h0000_0003;
      7:       sig_taps = 32'h0000_0003;
      8:       sig_taps = 32'h0000_001D;
      16:      sig_taps = 32'h0000_100B;
      32:      sig_taps = 32'h0040_0007;
      default: sig_taps = 32'h0000_0003;
    endcase
  endfunction

endpackage

// File: rtl/scan_chain_seg.sv
module scan_chain_seg #(
  parameter int unsigned LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           ser_in,
  input  logic [LEN-1:0] par_in,
  output logic [LEN-1:0] state_q
);

  logic [LEN-1:0] state_d;

  // Bit 0 is the head, bit LEN-1 the tail.
  always_comb begin
    if (shift_en) state_d = {state_q[LEN-2:0], ser_in};
    else          state_d = par_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sig_compactor.sv
module sig_compactor
  import scan_wrap_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned IN_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic [IN_W-1:0] data_in,
  output logic [W-1:0]    sig_q
);

  localparam logic [31:0]  TAPS32 = sig_taps(W);
  localparam logic [W-1:0] TAPS   = TAPS32[W-1:0];

  logic [W-1:0] ext_in;
  logic [W-1:0] sig_d;
  logic         sig_en;

  always_comb begin
    ext_in = '0;
    for (int i = 0; i < int'(IN_W); i++) ext_in[i] = data_in[i];
  end

  always_comb begin
    sig_en = clr | adv;
    if (clr) sig_d = '0;
    else     sig_d = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? TAPS : '0) ^ ext_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sig_q <= '0;
    else if (sig_en) sig_q <= sig_d;
  end

endmodule

// File: rtl/scan_bcast_wrap.sv
module scan_bcast_wrap #(
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned CHAIN_LEN  = 8,
  parameter int unsigned SIG_W      = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             scan_in,
  input  logic                             scan_en,
  input  logic                             bcast_mode,
  input  logic                             sig_clr,
  input  logic [NUM_CHAINS*CHAIN_LEN-1:0]  capture_bus,
  output logic                             scan_out,
  output logic [SIG_W-1:0]                 signature
);

  localparam int unsigned TOTAL = NUM_CHAINS * CHAIN_LEN;

  logic [1:0]            rst_pipe;
  logic                  rst_q_n;
  logic [NUM_CHAINS-1:0] head_in;
  logic [NUM_CHAINS-1:0] chain_tail;
  logic [TOTAL-1:0]      chain_q;

  // Asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  for (genvar k = 0; k < int'(NUM_CHAINS); k++) begin : g_chain
    if (k == 0) begin : g_first
      assign head_in[k] = scan_in;
    end else begin : g_rest
      assign head_in[k] = bcast_mode ? scan_in : chain_tail[k-1];
    end

    scan_chain_seg #(.LEN(CHAIN_LEN)) u_seg (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .shift_en (scan_en),
      .ser_in   (head_in[k]),
      .par_in   (capture_bus[k*CHAIN_LEN +: CHAIN_LEN]),
      .state_q  (chain_q[k*CHAIN_LEN +: CHAIN_LEN])
    );

    assign chain_tail[k] = chain_q[k*CHAIN_LEN + CHAIN_LEN - 1];
  end

  sig_compactor #(.W(SIG_W), .IN_W(NUM_CHAINS)) u_misr (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr     (sig_clr),
    .adv     (scan_en & bcast_mode),
    .data_in (chain_tail),
    .sig_q   (signature)
  );

  assign scan_out = chain_tail[NUM_CHAINS-1];

endmodule

// File: rtl/scan_bcast_wrap_chk.sv
module scan_bcast_wrap_chk #(
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned CHAIN_LEN  = 8,
  parameter int unsigned SIG_W      = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            scan_in,
  input logic                            scan_en,
  input logic                            bcast_mode,
  input logic                            sig_clr,
  input logic [NUM_CHAINS*CHAIN_LEN-1:0] capture_bus,
  input logic [NUM_CHAINS*CHAIN_LEN-1:0] chain_q,
  input logic [SIG_W-1:0]                signature
);

  localparam int unsigned L = CHAIN_LEN;

  assert_capture_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> chain_q == $past(capture_bus));

  assert_sig_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_clr && !(scan_en && bcast_mode)) |=> $stable(signature));

  assert_sig_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sig_clr |=> signature == '0);

  for (genvar k = 0; k < int'(NUM_CHAINS); k++) begin : g_k
    assert_bcast_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && bcast_mode) |=> chain_q[k*L] == $past(scan_in));

    if (k == 0) begin : g_h0
      assert_serial_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !bcast_mode) |=> chain_q[0] == $past(scan_in));
    end else begin : g_hk
      assert_serial_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !bcast_mode) |=> chain_q[k*L] == $past(chain_q[k*L-1]));
    end

    for (genvar j = 1; j < int'(L); j++) begin : g_j
      assert_inner_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> chain_q[k*L+j] == $past(chain_q[k*L+j-1]));
    end
  end

endmodule

bind scan_bcast_wrap scan_bcast_wrap_chk #(
  .NUM_CHAINS (NUM_CHAINS),
  .CHAIN_LEN  (CHAIN_LEN),
  .SIG_W      (SIG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .scan_in     (scan_in),
  .scan_en     (scan_en),
  .bcast_mode  (bcast_mode),
  .sig_clr     (sig_clr),
  .capture_bus (capture_bus),
  .chain_q     (chain_q),
  .signature   (signature)
);

// File: tb/scan_bcast_wrap_test.sv
module scan_bcast_wrap_test;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 3;
  localparam int L   = 3;
  localparam int W   = 5;
  localparam int TOT = N * L;
  localparam logic [W-1:0] TAPS = 5'h05;  // x^5+x^2+1 (R6)

  logic           clk = 1'b0;
  logic           rst_n;
  logic           scan_in, scan_en, bcast_mode, sig_clr;
  logic [TOT-1:0] capture_bus;
  logic           scan_out;
  logic [W-1:0]   signature;

  logic [TOT-1:0] m_q;
  logic [W-1:0]   m_sig;
  int             n_vec  = 0;
  int             n_miss = 0;
  bit             done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_bcast_wrap #(.NUM_CHAINS(N), .CHAIN_LEN(L), .SIG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .scan_en(scan_en),
    .bcast_mode(bcast_mode), .sig_clr(sig_clr), .capture_bus(capture_bus),
    .scan_out(scan_out), .signature(signature)
  );

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s scan_out actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_sig(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s signature actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic cyc(input logic si, input logic se, input logic bc,
                     input logic clr, input logic [TOT-1:0] cap);
    logic [TOT-1:0] nq;
    logic [W-1:0]   ns;
    logic [W-1:0]   tails;
    string          qtag;
    string          stag;
    scan_in = si; scan_en = se; bcast_mode = bc; sig_clr = clr; capture_bus = cap;
    @(posedge clk);
    tails = '0;
    for (int k = 0; k < N; k++) tails[k] = m_q[k*L+L-1];
    if (!se) nq = cap;                                  // R5
    else begin
      for (int k = 0; k < N; k++) begin
        nq[k*L] = (bc || k == 0) ? si : m_q[k*L-1];     // R2 / R3
        for (int j = 1; j < L; j++) nq[k*L+j] = m_q[k*L+j-1];  // R4
      end
    end
    if (clr)           ns = '0;                         // R8
    else if (se && bc) ns = {m_sig[W-2:0], 1'b0} ^ (m_sig[W-1] ? TAPS : '0) ^ tails; // R6
    else               ns = m_sig;                      // R7
    m_q = nq; m_sig = ns;
    qtag = !se ? "R5 capture" : (bc ? "R2 broadcast" : "R3 serial (R4 shift)");
    stag = clr ? "R8 clear" : ((se && bc) ? "R6 compaction" : "R7 hold");
    @(negedge clk);
    chk_bit(qtag, scan_out, m_q[TOT-1]);
    chk_sig(stag, signature, m_sig);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; scan_in = 1'b0; scan_en = 1'b1; bcast_mode = 1'b0;
    sig_clr = 1'b0; capture_bus = '0;
    m_q = '0; m_sig = '0;
    repeat (3) @(negedge clk);
    chk_bit("R1 reset", scan_out, 1'b0);
    chk_sig("R1 reset", signature, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);   // zeros shift in, state stays zero

    // Every capture pattern, unloaded through the serial concatenation.
    for (int p = 0; p < (1 << TOT); p++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0, TOT'(p));
      for (int b = 0; b < TOT; b++) cyc(~p[b], 1'b1, 1'b0, 1'b0, '0);
    end

    // Every pattern captured, compacted while a broadcast pattern loads,
    // then unloaded serially to show identical chains and a held signature.
    for (int p = 0; p < (1 << TOT); p++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b1, TOT'(p));
      for (int b = 0; b < L; b++) cyc(p[b], 1'b1, 1'b1, 1'b0, '0);
      for (int b = 0; b < TOT; b++) cyc(1'b0, 1'b1, 1'b0, 1'b0, '0);
    end

    // Pseudo-random mix of every mode and clear.
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], lfsr[1] | lfsr[2], lfsr[3], (lfsr[7:4] == 4'h0),
          TOT'(lfsr[15:7]));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule